// File: doc/BRIEF.md
# PHY Status Auto-Poll Change Detector

This block sits on top of an MDIO management master and keeps re-reading the PHY status register without any software help. It asks the master for one read, waits for the master to finish, and then waits a programmable number of MDC periods before asking again. The gap is measured in pulses on `mdc_tick_i`, which the master supplies once per MDC period.

The block keeps the most recent good result in a shadow register. The first good read after polling is switched on only loads the shadow. Every good read after that is compared with the shadow. If the value has changed, a sticky change flag is set, and the shadow takes the new value. The interrupt output is the change flag masked by an interrupt enable. Software clears the flag with a one-cycle clear pulse. Software can turn polling off when it wants to drive the PHY itself, and the next enable starts again with a seeding read.

Top module: `phy_autopoll`

## Requirements
- R1: While `en_i` is 0 the block holds `rd_req_o` low from the next cycle on. After `en_i` rises, `rd_req_o` goes high on the following cycle.
- R2: While `rd_req_o` is high, `rd_reg_o` is 1 (the PHY status register) and `rd_phy_o` equals `phy_addr_i`.
- R3: A read that completes with `rd_err_i` = 0 loads `rd_data_i` into `shadow_o`, which shows the new value one cycle after the `rd_done_i` cycle.
- R4: The first good read after polling is enabled only seeds the shadow. It leaves `chg_o` unchanged, even when the value differs from the old shadow.
- R5: A later good read sets `chg_o` when its data differs from `shadow_o`. When the data equals `shadow_o`, `chg_o` is left unchanged.
- R6: `irq_o` is 1 exactly when `chg_o` is 1 and `ie_i` is 1.
- R7: Once set, `chg_o` stays 1 until `clr_i` is high for a cycle. It then reads 0 on the next cycle.
- R8: A read that completes with `rd_err_i` = 1 leaves `shadow_o` and `chg_o` unchanged.
- R9: The gap between a completed read and the next request depends on `dly_i`, sampled at completion:
  - Code 0 keeps `rd_req_o` high, so the reads run back to back.
  - Code n (1 to 7) keeps `rd_req_o` low for exactly 2^(n+4) `mdc_tick_i` pulses (code 7 gives 2048).
- R10: Clearing `en_i` re-arms the seeding behaviour, so the first good read after the next enable again only loads the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Auto-poll enable |
| dly_i | input | 3 | Gap code between polls |
| phy_addr_i | input | 5 | PHY address to poll |
| ie_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Clear pulse for the change flag |
| mdc_tick_i | input | 1 | One pulse per MDC period |
| rd_req_o | output | 1 | Read request to the MDIO master, held until done |
| rd_phy_o | output | 5 | PHY address of the request |
| rd_reg_o | output | 5 | Register address of the request |
| rd_done_i | input | 1 | Read complete pulse from the master |
| rd_data_i | input | 16 | Read data from the master |
| rd_err_i | input | 1 | Read failed (valid with done) |
| shadow_o | output | 16 | Last good status value |
| chg_o | output | 1 | Sticky status-change flag |
| irq_o | output | 1 | Change interrupt |

## Verification
A wrong seeded bit shows up at the ports on the first compare. The bench sees either a false `chg_o` right after enabling, or a real change that is missed. This is visible one cycle after the offending `rd_done_i`.

A gap counter that is off by one shifts the next `rd_req_o` rise by one tick period. The bench catches this by counting ticks between the completed read and the next request.

A wrong state after disabling shows in two ways:
- `rd_req_o` stays high while polling is off.
- The seeding read after the next enable sets a change it should not.

// File: rtl/apoll_pkg.sv
package apoll_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP} apoll_st_e;

  // code 0 -> no gap, code n -> 2^(n+base) MDC periods
  function automatic int unsigned gap_periods(input int unsigned code, input int unsigned base);
    return (code == 0) ? 0 : (32'd1 << (code + base));
  endfunction
endpackage

// File: rtl/apoll_gap_timer.sv
module apoll_gap_timer #(
  parameter int DLY_W    = 3,
  parameter int GAP_BASE = 4,
  parameter int CNT_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] code_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             zero_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;

  assign len      = CNT_W'(apoll_pkg::gap_periods(32'(code_i), GAP_BASE));
  assign zero_o   = (code_i == '0);
  assign expire_o = run_i && tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (load_i)                        cnt_q <= len;
    else if (run_i && tick_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/apoll_seq.sv
module apoll_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  input  logic gap_zero_i,
  input  logic expire_i,
  output logic req_o,
  output logic run_o,
  output logic accept_o
);
  import apoll_pkg::*;
  apoll_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (en_i) st_d = ST_REQ;
      ST_REQ: begin
        if (!en_i)       st_d = ST_IDLE;
        else if (done_i) st_d = gap_zero_i ? ST_REQ : ST_GAP;
      end
      ST_GAP: begin
        if (!en_i)         st_d = ST_IDLE;
        else if (expire_i) st_d = ST_REQ;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign req_o    = (st_q == ST_REQ);
  assign run_o    = (st_q == ST_GAP);
  assign accept_o = req_o && done_i && en_i;
endmodule

// File: rtl/apoll_shadow_cmp.sv
module apoll_shadow_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              err_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rearm_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] shadow_o,
  output logic              chg_o
);
  logic seeded_q;
  logic good;
  logic diff;

  assign good = accept_i && !err_i;
  assign diff = seeded_q && (data_i != shadow_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      seeded_q <= 1'b0;
    end else if (rearm_i) begin
      seeded_q <= 1'b0;
    end else if (good) begin
      shadow_o <= data_i;
      seeded_q <= 1'b1;
    end
  end

  // a new change wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           chg_o <= 1'b0;
    else if (good && diff) chg_o <= 1'b1;
    else if (clr_i)        chg_o <= 1'b0;
  end
endmodule

// File: rtl/phy_autopoll.sv
module phy_autopoll #(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 5,
  parameter int          DLY_W    = 3,
  parameter int          GAP_BASE = 4,
  parameter int unsigned STAT_REG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic              ie_i,
  input  logic              clr_i,
  input  logic              mdc_tick_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_phy_o,
  output logic [ADDR_W-1:0] rd_reg_o,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_err_i,
  output logic [DATA_W-1:0] shadow_o,
  output logic              chg_o,
  output logic              irq_o
);
  localparam int unsigned MAX_GAP = apoll_pkg::gap_periods((1 << DLY_W) - 1, GAP_BASE);
  localparam int          CNT_W   = $clog2(MAX_GAP + 1);

  logic gap_zero, expire, run, accept;

  apoll_seq u_seq (
    .clk_i, .rst_ni, .en_i,
    .done_i(rd_done_i), .gap_zero_i(gap_zero), .expire_i(expire),
    .req_o(rd_req_o), .run_o(run), .accept_o(accept)
  );

  apoll_gap_timer #(.DLY_W(DLY_W), .GAP_BASE(GAP_BASE), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(accept), .code_i(dly_i), .run_i(run),
    .tick_i(mdc_tick_i), .zero_o(gap_zero), .expire_o(expire)
  );

  apoll_shadow_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk_i, .rst_ni, .accept_i(accept), .err_i(rd_err_i), .data_i(rd_data_i),
    .rearm_i(!en_i), .clr_i, .shadow_o, .chg_o
  );

  assign rd_phy_o = phy_addr_i;
  assign rd_reg_o = ADDR_W'(STAT_REG);
  assign irq_o    = chg_o && ie_i;
endmodule

// File: rtl/phy_autopoll_chk.sv
module phy_autopoll_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int DLY_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DLY_W-1:0]  dly_i,
  input logic [ADDR_W-1:0] phy_addr_i,
  input logic              ie_i,
  input logic              clr_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_phy_o,
  input logic              rd_done_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              rd_err_i,
  input logic [DATA_W-1:0] shadow_o,
  input logic              chg_o,
  input logic              irq_o
);
  p_no_req_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !rd_req_o);

  p_req_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_phy_o == phy_addr_i);

  p_shadow_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_done_i && !rd_err_i && en_i |=> shadow_o == $past(rd_data_i));

  p_chg_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_o ##1 chg_o |-> $past(rd_done_i) && $past(rd_req_o));

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> chg_o && ie_i);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o && !clr_i |=> chg_o);

  p_err_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_i && rd_err_i |=> $stable(shadow_o));

  p_gap_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_done_i && en_i && dly_i == '0 |=> rd_req_o);

  p_gap_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_done_i && en_i && dly_i != '0 |=> !rd_req_o);
endmodule

bind phy_autopoll phy_autopoll_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/phy_autopoll_test.sv
`timescale 1ns/1ps
module phy_autopoll_test;
  localparam int LAT  = 3;
  localparam int TDIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, ie = 0, clr = 0, tick = 0;
  logic [2:0] dly = 3'd1;
  logic [4:0] addr = 5'd9;
  logic rd_req, rd_done = 0, rd_err = 0;
  logic [4:0] rd_phy, rd_reg;
  logic [15:0] rd_data = '0, shadow;
  logic chg, irq;

  int checks = 0, fails = 0, n_reads = 0, lat = 0, tcnt = 0, gap_ticks = 0;
  logic [15:0] resp_data = '0;
  logic resp_err = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  phy_autopoll uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dly_i(dly), .phy_addr_i(addr),
    .ie_i(ie), .clr_i(clr), .mdc_tick_i(tick), .rd_req_o(rd_req),
    .rd_phy_o(rd_phy), .rd_reg_o(rd_reg), .rd_done_i(rd_done),
    .rd_data_i(rd_data), .rd_err_i(rd_err), .shadow_o(shadow), .chg_o(chg), .irq_o(irq)
  );

  // MDIO master model and tick source
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % TDIV;
    tick = (tcnt == 0);
    rd_done = 0;
    if (rd_req && !rd_done && rst_n) begin
      if (lat == LAT) begin
        rd_done = 1; rd_data = resp_data; rd_err = resp_err; lat = 0; n_reads++;
      end else lat++;
    end else lat = 0;
  end

  // tick count since the last completed read, while no request is up
  always @(posedge clk) begin
    if (rd_done) gap_ticks <= 0;
    else if (tick && !rd_req && en) gap_ticks <= gap_ticks + 1;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_read(input logic [15:0] d, input logic e);
    int n0;
    resp_data = d; resp_err = e; n0 = n_reads;
    while (n_reads == n0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset req", rd_req, 0);
    check("R3 reset shadow", shadow, 0);
    check("R6 reset irq", irq, 0);
    repeat (5) @(negedge clk);
    check("R1 no req while disabled", rd_req, 0);
  endtask

  task automatic t_seed;
    dly = 3'd1; en = 1;
    @(negedge clk);
    check("R1 req after enable", rd_req, 1);
    check("R2 reg addr", rd_reg, 1);
    check("R2 phy addr", rd_phy, 9);
    wait_read(16'h7809, 0);
    check("R3 seed shadow", shadow, 16'h7809);
    check("R4 seed no chg", chg, 0);
  endtask

  task automatic t_compare;
    ie = 1;
    wait_read(16'h7809, 0);
    check("R5 equal no chg", chg, 0);
    wait_read(16'h782d, 0);
    check("R5 diff sets chg", chg, 1);
    check("R3 shadow updated", shadow, 16'h782d);
    check("R6 irq on", irq, 1);
    ie = 0; @(negedge clk);
    check("R6 irq masked", irq, 0);
    ie = 1;
  endtask

  task automatic t_clear;
    wait_read(16'h782d, 0);
    check("R7 sticky", chg, 1);
    clr = 1; @(negedge clk); clr = 0;
    check("R7 cleared", chg, 0);
    check("R6 irq off after clear", irq, 0);
  endtask

  task automatic t_error;
    wait_read(16'h0000, 1);
    check("R8 err keeps shadow", shadow, 16'h782d);
    check("R8 err no chg", chg, 0);
  endtask

  task automatic t_gap(input logic [2:0] code);
    int exp;
    dly = code;
    wait_read(16'h782d, 0);
    exp = (code == 0) ? 0 : (1 << (code + 4));
    while (!rd_req) @(negedge clk);
    check($sformatf("R9 gap ticks code %0d", code), gap_ticks, exp);
  endtask

  task automatic t_gap0;
    int n0;
    dly = 3'd0;
    resp_data = 16'h782d; resp_err = 0; n0 = n_reads;
    while (n_reads == n0) @(negedge clk);
    check("R9 code0 req held", rd_req, 1);
    check("R9 code0 no ticks", gap_ticks, 0);
    dly = 3'd1;
    wait_read(16'h782d, 0);
  endtask

  task automatic t_rearm;
    en = 0; @(negedge clk); @(negedge clk);
    check("R1 req drops on disable", rd_req, 0);
    repeat (100) @(negedge clk);
    check("R1 stays idle", rd_req, 0);
    en = 1;
    wait_read(16'h1111, 0);
    check("R10 reseed shadow", shadow, 16'h1111);
    check("R10 reseed no chg", chg, 0);
    wait_read(16'h1110, 0);
    check("R10 compare after reseed", chg, 1);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_seed();
    t_compare();
    t_clear();
    t_error();
    t_gap(3'd1);
    t_gap(3'd3);
    t_gap(3'd7);
    t_gap0();
    t_rearm();
    finish_run();
  end
endmodule